// File: doc/BRIEF.md
# Timer Status Flag Bank with Access-Triggered Clearing

This block holds the sticky status flags of a multi-channel capture/compare timer. The timer hands it single-cycle event pulses: one per channel, a counter wrap, an overflow and an input edge from the first pulse accumulator, an overflow from the second pulse accumulator, and the modulus down-counter reaching zero. Each pulse sets its flag on the next clock edge. The flag stays set until it is cleared. A per-flag enable mask combines the flags into a single interrupt request.

Software reaches the flags over a simple register bus with address, read strobe, write strobe and data. Two clearing policies exist, and a control bit selects one of them. In the normal policy, writing ones to a flag register clears those flags. In the fast policy, that write is ignored. Instead the block watches bus traffic to the timer's data registers, which live in other blocks, and clears the flag that belongs to the register being touched. A per-channel direction bit decides whether a channel acts as capture or as compare. A capture channel's flag clears when its data register is read. A compare channel's flag clears when its data register is written.

Top module: `tflag_bank`

## Requirements
- R1: After reset every flag is 0, every control, direction and enable register is 0, and `irq` is 0.
- R2: An event pulse sets its flag at the next clock edge. The flag stays 1 on later cycles with no event and no clear. Channel flag i is `ch_flags[i]`. Auxiliary flags are `aux_flags`: bit 0 counter wrap, bit 1 accumulator A overflow, bit 2 accumulator A edge, bit 3 accumulator B overflow, bit 4 modulus zero.
- R3: With the mode bit (bit 0 at address 2) at 0, a write to address 0 (channel flags) or address 1 (auxiliary flags) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: With the mode bit at 1, writes to addresses 0 and 1 change no flag.
- R5: In fast mode, a read of channel data register i (address 16+i) clears channel flag i when direction bit i (address 3) is 0, meaning capture. A write to that register does not clear the flag of a capture channel.
- R6: In fast mode, a write to channel data register i clears channel flag i when direction bit i is 1, meaning compare. A read of that register does not clear the flag of a compare channel.
- R7: In fast mode, a read or a write of the counter register (address 32) clears the counter-wrap flag.
- R8: In fast mode, any access to either accumulator A count register (address 33 or 34) clears both accumulator A flags.
- R9: In fast mode, any access to either accumulator B count register (address 35 or 36) clears the accumulator B overflow flag.
- R10: In fast mode, any access to the modulus count register (address 37) clears the modulus-zero flag.
- R11: In normal mode, accesses to addresses 16 through 37 leave every flag unchanged.
- R12: When an event and a clearing action hit the same flag in the same cycle, the flag is 1 afterwards.
- R13: `irq` is 1 exactly when some flag is 1 and its enable bit is also 1. Channel enables are at address 4 and auxiliary enables at address 5, with the same bit layout as the flags.
- R14: While `bus_rd` is high, `bus_rdata` returns the flag, control, direction or enable register at the current address, zero-extended. All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ch | input | NCH | Per-channel event pulses |
| ev_ovf | input | 1 | Counter wrap pulse |
| ev_pa_ovf | input | 1 | Accumulator A overflow pulse |
| ev_pa_edge | input | 1 | Accumulator A input edge pulse |
| ev_pb_ovf | input | 1 | Accumulator B overflow pulse |
| ev_mz | input | 1 | Modulus counter zero pulse |
| bus_addr | input | AW | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| ch_flags | output | NCH | Channel flags |
| aux_flags | output | 5 | Auxiliary flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: eight channels, a six-bit address and a sixteen-bit data bus. The direction mask 0xAA makes the odd channels compare channels and the even channels capture channels, so a single build covers both read-triggered and write-triggered clearing. Because the data bus is wider than the channel count, a single write-one-to-clear word can reach every channel flag. The two-address accumulator windows and the set-beats-clear cases on both flag groups are also covered.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
   localparam int AUX_W        = 5;
   localparam int AUX_OVF      = 0;
   localparam int AUX_PAA_OVF  = 1;
   localparam int AUX_PAA_EDGE = 2;
   localparam int AUX_PAB_OVF  = 3;
   localparam int AUX_MZ       = 4;

   // own register window
   localparam int ADR_CHF   = 0;
   localparam int ADR_AUXF  = 1;
   localparam int ADR_CTRL  = 2;
   localparam int ADR_DIR   = 3;
   localparam int ADR_CHEN  = 4;
   localparam int ADR_AUXEN = 5;
   // snooped data registers owned by neighbouring blocks
   localparam int ADR_CH_BASE = 16;
   localparam int ADR_CNT     = 32;
   localparam int ADR_PAA_0   = 33;
   localparam int ADR_PAA_1   = 34;
   localparam int ADR_PAB_0   = 35;
   localparam int ADR_PAB_1   = 36;
   localparam int ADR_MOD     = 37;
   localparam int ADR_MIN_W   = 6;
endpackage

// File: rtl/tflag_store.sv
module tflag_store #(
   parameter int W        = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   logic [W-1:0] d;

   generate
      if (SET_WINS) begin : g_set_first
         assign d = (q & ~clr) | set;
      end else begin : g_clr_first
         assign d = (q | set) & ~clr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   // R2 / R12: a pulse always lands, even against a clear
   generate
      if (SET_WINS) begin : g_chk_set
         a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (set != '0) |=> ((q & $past(set)) == $past(set)));
      end
   endgenerate

   // R2: no flag rises without a pulse
   a_r2_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));
endmodule

// File: rtl/tflag_clrgen.sv
module tflag_clrgen
   import tflag_pkg::*;
#(
   parameter int NCH = 8,
   parameter int AW  = 6,
   parameter int DW  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast,
   input  logic [NCH-1:0]   dir,
   input  logic [AW-1:0]    addr,
   input  logic             rd,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   output logic [NCH-1:0]   clr_ch,
   output logic [AUX_W-1:0] clr_aux
);
   localparam logic [AW-1:0] A_CHF  = AW'(ADR_CHF);
   localparam logic [AW-1:0] A_AUXF = AW'(ADR_AUXF);
   localparam logic [AW-1:0] A_CNT  = AW'(ADR_CNT);
   localparam logic [AW-1:0] A_PA0  = AW'(ADR_PAA_0);
   localparam logic [AW-1:0] A_PA1  = AW'(ADR_PAA_1);
   localparam logic [AW-1:0] A_PB0  = AW'(ADR_PAB_0);
   localparam logic [AW-1:0] A_PB1  = AW'(ADR_PAB_1);
   localparam logic [AW-1:0] A_MOD  = AW'(ADR_MOD);

   logic               acc;
   logic               w1c_ok;
   logic [NCH-1:0]     w1c_ch;
   logic [AUX_W-1:0]   w1c_aux;
   logic [NCH-1:0]     snp_ch;
   logic [AUX_W-1:0]   snp_aux;

   assign acc    = rd | wr;
   assign w1c_ok = wr & ~fast;

   assign w1c_ch  = (w1c_ok && addr == A_CHF)  ? wdata[NCH-1:0]   : '0;
   assign w1c_aux = (w1c_ok && addr == A_AUXF) ? wdata[AUX_W-1:0] : '0;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         localparam logic [AW-1:0] A_CH = AW'(ADR_CH_BASE + i);
         logic hit;
         assign hit       = (addr == A_CH);
         assign snp_ch[i] = fast & hit & (dir[i] ? wr : rd);
      end
   endgenerate

   always_comb begin
      snp_aux = '0;
      if (fast && acc) begin
         snp_aux[AUX_OVF]      = (addr == A_CNT);
         snp_aux[AUX_PAA_OVF]  = (addr == A_PA0) || (addr == A_PA1);
         snp_aux[AUX_PAA_EDGE] = (addr == A_PA0) || (addr == A_PA1);
         snp_aux[AUX_PAB_OVF]  = (addr == A_PB0) || (addr == A_PB1);
         snp_aux[AUX_MZ]       = (addr == A_MOD);
      end
   end

   assign clr_ch  = w1c_ch | snp_ch;
   assign clr_aux = w1c_aux | snp_aux;

   // R11: in normal mode only a flag-register write may clear
   a_r11_normal_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      (!fast && !(wr && (addr == A_CHF || addr == A_AUXF))) |-> (clr_ch == '0 && clr_aux == '0));
   // R4: in fast mode a flag-register write clears nothing
   a_r4_fast_no_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && (addr == A_CHF || addr == A_AUXF)) |-> (clr_ch == '0 && clr_aux == '0));
   // R5: a pure read never clears a compare channel
   a_r5_read_spares_compare: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && rd && !wr) |-> ((clr_ch & dir) == '0));
   // R6: a pure write never clears a capture channel
   a_r6_write_spares_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && wr && !rd) |-> ((clr_ch & ~dir) == '0));
endmodule

// File: rtl/tflag_regs.sv
module tflag_regs
   import tflag_pkg::*;
#(
   parameter int NCH = 8,
   parameter int AW  = 6,
   parameter int DW  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr,
   input  logic             rd,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   input  logic [NCH-1:0]   ch_q,
   input  logic [AUX_W-1:0] aux_q,
   output logic             fast,
   output logic [NCH-1:0]   dir,
   output logic [NCH-1:0]   ch_en,
   output logic [AUX_W-1:0] aux_en,
   output logic [DW-1:0]    rdata
);
   localparam logic [AW-1:0] A_CHF   = AW'(ADR_CHF);
   localparam logic [AW-1:0] A_AUXF  = AW'(ADR_AUXF);
   localparam logic [AW-1:0] A_CTRL  = AW'(ADR_CTRL);
   localparam logic [AW-1:0] A_DIR   = AW'(ADR_DIR);
   localparam logic [AW-1:0] A_CHEN  = AW'(ADR_CHEN);
   localparam logic [AW-1:0] A_AUXEN = AW'(ADR_AUXEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast   <= 1'b0;
         dir    <= '0;
         ch_en  <= '0;
         aux_en <= '0;
      end else if (wr) begin
         case (addr)
            A_CTRL:  fast   <= wdata[0];
            A_DIR:   dir    <= wdata[NCH-1:0];
            A_CHEN:  ch_en  <= wdata[NCH-1:0];
            A_AUXEN: aux_en <= wdata[AUX_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            A_CHF:   rdata = DW'(ch_q);
            A_AUXF:  rdata = DW'(aux_q);
            A_CTRL:  rdata = DW'(fast);
            A_DIR:   rdata = DW'(dir);
            A_CHEN:  rdata = DW'(ch_en);
            A_AUXEN: rdata = DW'(aux_en);
            default: rdata = '0;
         endcase
      end
   end

   // R14: idle bus reads as zero
   a_r14_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));
endmodule

// File: rtl/tflag_bank.sv
module tflag_bank
   import tflag_pkg::*;
#(
   parameter int NCH = 8,
   parameter int AW  = 6,
   parameter int DW  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   ev_ch,
   input  logic             ev_ovf,
   input  logic             ev_pa_ovf,
   input  logic             ev_pa_edge,
   input  logic             ev_pb_ovf,
   input  logic             ev_mz,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   output logic [NCH-1:0]   ch_flags,
   output logic [AUX_W-1:0] aux_flags,
   output logic             irq
);
   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("tflag_bank: NCH must lie in 1..16");
      end
      if (DW < NCH || DW < AUX_W) begin : g_bad_dw
         $error("tflag_bank: DW narrower than a flag register");
      end
      if (AW < ADR_MIN_W) begin : g_bad_aw
         $error("tflag_bank: AW too small for the snoop window");
      end
   endgenerate

   localparam logic [AW-1:0] A_CNT = AW'(ADR_CNT);

   logic               fast;
   logic [NCH-1:0]     dir;
   logic [NCH-1:0]     ch_en;
   logic [AUX_W-1:0]   aux_en;
   logic [NCH-1:0]     clr_ch;
   logic [AUX_W-1:0]   clr_aux;
   logic [AUX_W-1:0]   ev_aux;

   always_comb begin
      ev_aux               = '0;
      ev_aux[AUX_OVF]      = ev_ovf;
      ev_aux[AUX_PAA_OVF]  = ev_pa_ovf;
      ev_aux[AUX_PAA_EDGE] = ev_pa_edge;
      ev_aux[AUX_PAB_OVF]  = ev_pb_ovf;
      ev_aux[AUX_MZ]       = ev_mz;
   end

   tflag_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .ch_q   (ch_flags),
      .aux_q  (aux_flags),
      .fast   (fast),
      .dir    (dir),
      .ch_en  (ch_en),
      .aux_en (aux_en),
      .rdata  (bus_rdata)
   );

   tflag_clrgen #(.NCH(NCH), .AW(AW), .DW(DW)) u_clr (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast    (fast),
      .dir     (dir),
      .addr    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .clr_ch  (clr_ch),
      .clr_aux (clr_aux)
   );

   tflag_store #(.W(NCH), .SET_WINS(1'b1)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_ch),
      .clr   (clr_ch),
      .q     (ch_flags)
   );

   tflag_store #(.W(AUX_W), .SET_WINS(1'b1)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_aux),
      .clr   (clr_aux),
      .q     (aux_flags)
   );

   assign irq = |(ch_flags & ch_en) | |(aux_flags & aux_en);

   // R13: no enabled flag, no request
   a_r13_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((ch_flags & ch_en) == '0 && (aux_flags & aux_en) == '0) |-> !irq);
   // R7: a counter access in fast mode drops the wrap flag
   a_r7_counter_access: assert property (@(posedge clk) disable iff (!rst_n)
      (fast && (bus_rd || bus_wr) && bus_addr == A_CNT && !ev_ovf) |=> !aux_flags[AUX_OVF]);
endmodule

// File: tb/sim_tflag_bank.sv
module sim_tflag_bank;
   localparam int NCH = 8;
   localparam int AW  = 6;
   localparam int DW  = 16;
   localparam int NV  = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NCH-1:0] ev_ch = '0;
   logic          ev_ovf = 0, ev_pa_ovf = 0, ev_pa_edge = 0, ev_pb_ovf = 0, ev_mz = 0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 0, bus_wr = 0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NCH-1:0] ch_flags;
   logic [4:0]    aux_flags;
   logic          irq;

   int nchk = 0;
   int nbad = 0;

   always #4 clk = ~clk;

   tflag_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_ch(ev_ch), .ev_ovf(ev_ovf),
      .ev_pa_ovf(ev_pa_ovf), .ev_pa_edge(ev_pa_edge), .ev_pb_ovf(ev_pb_ovf),
      .ev_mz(ev_mz), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_flags(ch_flags),
      .aux_flags(aux_flags), .irq(irq)
   );

   // op[49:48] 0 idle 1 write 2 read | addr[47:42] | wdata[41:26]
   // ev_ch[25:18] | ev_aux[17:13] | exp_ch[12:5] | exp_aux[4:0]
   localparam logic [49:0] VEC [NV] = '{
      {2'd0, 6'd0,  16'h0000, 8'hFF, 5'h1F, 8'hFF, 5'h1F}, // 0  R2 set
      {2'd0, 6'd0,  16'h0000, 8'h00, 5'h00, 8'hFF, 5'h1F}, // 1  R2 sticky
      {2'd1, 6'd0,  16'h000F, 8'h00, 5'h00, 8'hF0, 5'h1F}, // 2  R3 w1c
      {2'd1, 6'd0,  16'h0000, 8'h00, 5'h00, 8'hF0, 5'h1F}, // 3  R3 zeros
      {2'd1, 6'd1,  16'h0005, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 4  R3 aux
      {2'd2, 6'd16, 16'h0000, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 5  R11 read
      {2'd1, 6'd37, 16'hFFFF, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 6  R11 write
      {2'd1, 6'd3,  16'h00AA, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 7  dir
      {2'd1, 6'd2,  16'h0001, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 8  fast on
      {2'd1, 6'd0,  16'h00FF, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 9  R4
      {2'd1, 6'd1,  16'h001F, 8'h00, 5'h00, 8'hF0, 5'h1A}, // 10 R4
      {2'd0, 6'd0,  16'h0000, 8'h0F, 5'h05, 8'hFF, 5'h1F}, // 11 refill
      {2'd2, 6'd16, 16'h0000, 8'h00, 5'h00, 8'hFE, 5'h1F}, // 12 R5 read cap
      {2'd1, 6'd18, 16'h1234, 8'h00, 5'h00, 8'hFE, 5'h1F}, // 13 R5 write cap
      {2'd2, 6'd17, 16'h0000, 8'h00, 5'h00, 8'hFE, 5'h1F}, // 14 R6 read cmp
      {2'd1, 6'd17, 16'h0042, 8'h00, 5'h00, 8'hFC, 5'h1F}, // 15 R6 write cmp
      {2'd2, 6'd32, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h1E}, // 16 R7 read
      {2'd0, 6'd0,  16'h0000, 8'h00, 5'h01, 8'hFC, 5'h1F}, // 17
      {2'd1, 6'd32, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h1E}, // 18 R7 write
      {2'd2, 6'd34, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h18}, // 19 R8
      {2'd0, 6'd0,  16'h0000, 8'h00, 5'h06, 8'hFC, 5'h1E}, // 20
      {2'd1, 6'd33, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h18}, // 21 R8
      {2'd2, 6'd36, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h10}, // 22 R9
      {2'd1, 6'd37, 16'h0000, 8'h00, 5'h00, 8'hFC, 5'h00}, // 23 R10
      {2'd2, 6'd2,  16'h0000, 8'h00, 5'h00, 8'hFC, 5'h00}, // 24 ctrl read
      {2'd1, 6'd19, 16'h0000, 8'h08, 5'h00, 8'hFC, 5'h00}, // 25 R12 ch
      {2'd1, 6'd19, 16'h0000, 8'h00, 5'h00, 8'hF4, 5'h00}, // 26 R6
      {2'd2, 6'd35, 16'h0000, 8'h00, 5'h08, 8'hF4, 5'h08}, // 27 R12 aux
      {2'd1, 6'd2,  16'h0000, 8'h00, 5'h00, 8'hF4, 5'h08}, // 28 normal
      {2'd1, 6'd0,  16'h00F4, 8'h04, 5'h00, 8'h04, 5'h08}  // 29 R12 w1c
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NCH-1:0] ec, input logic [4:0] ea);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = (op == 2'd1); bus_rd = (op == 2'd2);
      ev_ch = ec;
      {ev_mz, ev_pb_ovf, ev_pa_edge, ev_pa_ovf, ev_ovf} = ea;
      @(posedge clk);
      #2;
      bus_wr = 0; bus_rd = 0; ev_ch = '0;
      {ev_mz, ev_pb_ovf, ev_pa_edge, ev_pa_ovf, ev_ovf} = '0;
   endtask

   task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      #1;
      chk(req, 32'(bus_rdata), 32'(exp));
      @(posedge clk);
      #2;
      bus_rd = 0;
   endtask

   initial begin
      #(8 * 20000);
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk("R1 ch", 32'(ch_flags), 32'h0);
      chk("R1 aux", 32'(aux_flags), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      rst_n = 1;
      for (int a = 2; a < 6; a++) rdchk("R1 regs", AW'(a), '0);

      for (int i = 0; i < NV; i++) begin
         cyc(VEC[i][49:48], VEC[i][47:42], VEC[i][41:26], VEC[i][25:18], VEC[i][17:13]);
         chk($sformatf("R2-table v%0d ch", i), 32'(ch_flags), 32'(VEC[i][12:5]));
         chk($sformatf("R2-table v%0d aux", i), 32'(aux_flags), 32'(VEC[i][4:0]));
      end

      // R14 readback
      rdchk("R14 dir", 6'd3, 16'h00AA);
      rdchk("R14 ctrl", 6'd2, 16'h0000);
      rdchk("R14 chflags", 6'd0, 16'h0004);
      rdchk("R14 auxflags", 6'd1, 16'h0008);
      rdchk("R14 data window", 6'd16, 16'h0000);
      chk("R14 idle", 32'(bus_rdata), 32'h0);

      // R13 interrupt combining; flags now ch=04 aux=08
      chk("R13 none enabled", 32'(irq), 32'h0);
      cyc(2'd1, 6'd4, 16'h0001, '0, '0);
      chk("R13 wrong ch enable", 32'(irq), 32'h0);
      cyc(2'd1, 6'd4, 16'h0004, '0, '0);
      chk("R13 ch enable", 32'(irq), 32'h1);
      cyc(2'd1, 6'd4, 16'h0000, '0, '0);
      cyc(2'd1, 6'd5, 16'h0010, '0, '0);
      chk("R13 wrong aux enable", 32'(irq), 32'h0);
      cyc(2'd1, 6'd5, 16'h0008, '0, '0);
      chk("R13 aux enable", 32'(irq), 32'h1);
      rdchk("R14 auxen", 6'd5, 16'h0008);

      // R1 reset in the middle of a run
      @(negedge clk);
      rst_n = 0;
      #1;
      chk("R1 mid ch", 32'(ch_flags), 32'h0);
      chk("R1 mid aux", 32'(aux_flags), 32'h0);
      chk("R1 mid irq", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1;
      rdchk("R1 mid auxen", 6'd5, 16'h0000);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule